// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several privilege modes. Some logical registers have a private physical copy in certain modes. One write port and two combinational read ports take a logical register number, and the block maps it to a physical entry using the current 5-bit mode. The fast-interrupt mode has a private copy of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have a private copy of registers 13 and 14 only. User and system modes share the base copies.

Block-transfer instructions with the user-bank flag need the user copies while the core stays in a privileged mode. An override input makes all three ports use the user copies. There is one exception: a load-multiple whose list holds register 15. For that transfer the override is not applied. Instead the block raises a flag that tells the core to restore its status word from the saved copy.

Top module: `banked_regfile`

## Requirements
- R1: Mode codes 10000 (user) and 11111 (system) use the same physical registers for all sixteen numbers. Every mode code not named in R1, R2 or R3 behaves as user.
- R2: In mode 10001 (fast interrupt), registers 8 to 14 have private copies. A write to them in that mode leaves the user copies unchanged, and the reverse also holds.
- R3: Modes 10010 (interrupt), 10011 (supervisor), 10111 (abort) and 11011 (undefined) each have their own private copy of registers 13 and 14. In these modes registers 8 to 12 are the user copies.
- R4: When `usr_bank` is high and `pc_load` is low in a privileged mode, reads and writes of that mode's banked registers reach the user copies. All other registers behave as without the override.
- R5: When `usr_bank` is high in user mode (or any mode that behaves as user), it has no effect on any port.
- R6: `restore_status` equals `usr_bank & pc_load` combinationally, in every mode. While both are high, the override is not applied and accesses use the mode's own copies.
- R7: Registers 0 to 7 and register 15 have a single physical copy, shared by every mode and by override accesses.
- R8: A write with `wr_en` high takes effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R9: With `rst_n` low at a rising edge, every physical copy clears to zero.
- R10: The two read ports are independent. Each one maps its own register number through the same mode view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 5 | Current processor mode code |
| usr_bank | input | 1 | Request to reach the user copies |
| pc_load | input | 1 | The current transfer is a load whose list includes register 15 |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| restore_status | output | 1 | Tells the core to restore its status word from the saved copy |

## Verification
A wrong mapping to a physical entry is silent when it is written. It shows only when another mode, or the override, reads the same logical number later. The bench therefore writes a distinct value into every copy first, then reads each logical register from every mode view. A misrouted write then appears on the read ports in the first read after it. Corruption of a shared register (0 to 7 or 15) shows in every mode at once. A slip in the override or restore gating shows in the same cycle on `restore_status`, and on the next read of the copy it should have left untouched.

// File: rtl/bank_pkg.sv
// Shared constants and types for the mode-banked register file.
// Assumes the architectural layout: 16 logical registers, one 7-entry
// fast-interrupt bank and four 2-entry banks for the other privileged modes.
package bank_pkg;
    localparam int LREGS      = 16;
    localparam int IDX_W      = $clog2(LREGS);
    localparam int MODE_W     = 5;
    localparam int FIQ_LO     = 8;
    localparam int SHORT_LO   = 13;
    localparam int BANK_HI    = 14;
    localparam int PC_IDX     = 15;
    localparam int FIQ_CNT    = BANK_HI - FIQ_LO + 1;
    localparam int SHORT_CNT  = BANK_HI - SHORT_LO + 1;
    localparam int SHORT_MODES = 4;
    localparam int FIQ_BASE   = LREGS;
    localparam int SHORT_BASE = FIQ_BASE + FIQ_CNT;
    localparam int PHYS       = SHORT_BASE + SHORT_MODES * SHORT_CNT;
    localparam int PHYS_W     = $clog2(PHYS);

    localparam logic [MODE_W-1:0] MD_USER  = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FAST  = 5'b10001;
    localparam logic [MODE_W-1:0] MD_INTR  = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SUPV  = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABRT  = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UNDF  = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYST  = 5'b11111;

    // Register view; the short-bank views are ordered to index their slot.
    typedef enum logic [2:0] {
        VW_USER = 3'd0,
        VW_FAST = 3'd1,
        VW_INTR = 3'd2,
        VW_SUPV = 3'd3,
        VW_ABRT = 3'd4,
        VW_UNDF = 3'd5
    } view_e;
endpackage

// File: rtl/rf_view_sel.sv
// Turns the mode code and the override controls into the register view used
// by all ports, and raises the status-restore flag.
// Assumes mode codes outside the named set act as the user view.
module rf_view_sel
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              usr_bank,
    input  logic              pc_load,
    output view_e             view,
    output logic              restore_status
);
    view_e mode_view;

    // Decode the raw mode code into its own view.
    always_comb begin
        unique case (mode)
            MD_FAST: mode_view = VW_FAST;
            MD_INTR: mode_view = VW_INTR;
            MD_SUPV: mode_view = VW_SUPV;
            MD_ABRT: mode_view = VW_ABRT;
            MD_UNDF: mode_view = VW_UNDF;
            default: mode_view = VW_USER;
        endcase
    end

    // Apply the override unless the transfer reloads register 15.
    always_comb begin
        restore_status = usr_bank & pc_load;
        if (usr_bank && !pc_load)
            view = VW_USER;
        else
            view = mode_view;
    end

    AST_OVR_USER_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_bank && !pc_load) |-> (view == VW_USER)); // R4
    AST_RESTORE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_status |-> (view == mode_view)); // R6
    AST_SYSTEM_IS_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SYST) |-> (view == VW_USER)); // R1
endmodule

// File: rtl/rf_phys_map.sv
// Maps one logical register number to its physical entry for a given view.
// Assumes the view already includes the override decision.
module rf_phys_map
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  view_e             view,
    input  logic [IDX_W-1:0]  lidx,
    output logic [PHYS_W-1:0] pidx
);
    logic in_fast_range;
    logic in_short_range;
    logic short_view;
    int   slot;

    // Classify the register number against the banked ranges.
    always_comb begin
        in_fast_range  = (int'(lidx) >= FIQ_LO)   && (int'(lidx) <= BANK_HI);
        in_short_range = (int'(lidx) >= SHORT_LO) && (int'(lidx) <= BANK_HI);
        short_view     = (view == VW_INTR) || (view == VW_SUPV) ||
                         (view == VW_ABRT) || (view == VW_UNDF);
        slot           = int'(view) - int'(VW_INTR);
    end

    // Pick the physical entry: fast bank, short bank slot or the base copy.
    always_comb begin
        if (view == VW_FAST && in_fast_range)
            pidx = PHYS_W'(FIQ_BASE + int'(lidx) - FIQ_LO);
        else if (short_view && in_short_range)
            pidx = PHYS_W'(SHORT_BASE + slot * SHORT_CNT + int'(lidx) - SHORT_LO);
        else
            pidx = PHYS_W'(lidx);
    end

    AST_LOW_REGS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lidx) < FIQ_LO) |-> (pidx == PHYS_W'(lidx))); // R7
    AST_PC_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lidx) == PC_IDX) |-> (pidx == PHYS_W'(PC_IDX))); // R7
    AST_USER_BASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (view == VW_USER) |-> (int'(pidx) < LREGS)); // R1
    AST_FAST_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        (view == VW_FAST && in_fast_range) |-> (int'(pidx) >= FIQ_BASE && int'(pidx) < SHORT_BASE)); // R2
endmodule

// File: rtl/rf_store.sv
// Physical register array: one write port, two combinational read ports.
// Assumes physical indices are already resolved; reads see pre-edge values.
module rf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 31,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [AW-1:0]     rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] regs [DEPTH];

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            // Clear on reset, otherwise load when this entry is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[e] <= '0;
                else if (wr_en && (int'(wr_addr) == e))
                    regs[e] <= wr_data;
            end
        end
    endgenerate

    // Read both ports straight from the array.
    always_comb begin
        ra_data = (int'(ra_addr) < DEPTH) ? regs[ra_addr] : '0;
        rb_data = (int'(rb_addr) < DEPTH) ? regs[rb_addr] : '0;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_addr)] == $past(wr_data))); // R8
    AST_READ_A_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $stable(ra_addr)) |=> $stable(ra_data)); // R10
endmodule

// File: rtl/banked_regfile.sv
// Top of the mode-banked register file. Resolves one write and two read
// register numbers through the current mode view into the physical array.
// Assumes the mode, override and transfer controls are stable within a cycle.
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode,
    input  logic              usr_bank,
    input  logic              pc_load,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              restore_status
);
    localparam int NPORTS = 3;

    view_e             view;
    logic [IDX_W-1:0]  lidx [NPORTS];
    logic [PHYS_W-1:0] pidx [NPORTS];

    rf_view_sel i_view (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode           (mode),
        .usr_bank       (usr_bank),
        .pc_load        (pc_load),
        .view           (view),
        .restore_status (restore_status)
    );

    // Gather the port register numbers: write, read A, read B.
    always_comb begin
        lidx[0] = wr_idx;
        lidx[1] = rd_a_idx;
        lidx[2] = rd_b_idx;
    end

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_map
            rf_phys_map i_map (
                .clk   (clk),
                .rst_n (rst_n),
                .view  (view),
                .lidx  (lidx[p]),
                .pidx  (pidx[p])
            );
        end
    endgenerate

    rf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (PHYS)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (pidx[0]),
        .wr_data (wr_data),
        .ra_addr (pidx[1]),
        .ra_data (rd_a_data),
        .rb_addr (pidx[2]),
        .rb_data (rd_b_data)
    );

    AST_RESTORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        restore_status |-> (usr_bank && pc_load)); // R6
    AST_SAME_IDX_SAME_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data)); // R10
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic        usr_bank = 1'b0;
    logic        pc_load = 1'b0;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        restore_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [4:0] USR = 5'b10000, FST = 5'b10001, INT = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111, ODD = 5'b00101;

    // Reference copies built from the requirements.
    logic [31:0] m_usr [16];
    logic [31:0] m_fst [7];
    logic [31:0] m_sh  [4][2];

    always #4 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst_n(rst_n), .mode(mode), .usr_bank(usr_bank),
        .pc_load(pc_load), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .restore_status(restore_status)
    );

    function automatic int bank_of(input logic [4:0] m, input logic ov, input logic pl);
        int b;
        case (m)
            FST: b = 1; INT: b = 2; SVC: b = 3; ABT: b = 4; UND: b = 5;
            default: b = 0;
        endcase
        if (ov && !pl) b = 0;
        return b;
    endfunction

    function automatic logic [31:0] expect_rd(input logic [4:0] m, input logic ov,
                                              input logic pl, input int r);
        int b = bank_of(m, ov, pl);
        if (b == 1 && r >= 8 && r <= 14) return m_fst[r-8];
        if (b >= 2 && r >= 13 && r <= 14) return m_sh[b-2][r-13];
        return m_usr[r];
    endfunction

    task automatic model_wr(input logic [4:0] m, input logic ov, input logic pl,
                            input int r, input logic [31:0] d);
        int b = bank_of(m, ov, pl);
        if (b == 1 && r >= 8 && r <= 14) m_fst[r-8] = d;
        else if (b >= 2 && r >= 13 && r <= 14) m_sh[b-2][r-13] = d;
        else m_usr[r] = d;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_view(input logic [4:0] m, input logic ov, input logic pl);
        mode = m; usr_bank = ov; pc_load = pl;
    endtask

    // One write through the port; returns 1 ns after the edge.
    task automatic put(input logic [4:0] m, input logic ov, input logic pl,
                       input int r, input logic [31:0] d);
        @(negedge clk);
        set_view(m, ov, pl);
        wr_en = 1'b1; wr_idx = 4'(r); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_wr(m, ov, pl, r, d);
    endtask

    // Read one register on port A and the next number on port B.
    task automatic get(input string req, input logic [4:0] m, input logic ov,
                       input logic pl, input int r);
        set_view(m, ov, pl);
        rd_a_idx = 4'(r); rd_b_idx = 4'((r + 1) % 16);
        #1;
        check(req, rd_a_data, expect_rd(m, ov, pl, r));
        check(req, rd_b_data, expect_rd(m, ov, pl, (r + 1) % 16));
    endtask

    task automatic t_reset;   // R9
        for (int r = 0; r < 16; r++) begin
            get("R9", USR, 1'b0, 1'b0, r);
            get("R9", FST, 1'b0, 1'b0, r);
            get("R9", UND, 1'b0, 1'b0, r);
        end
    endtask

    task automatic t_fill;   // distinct value in every copy
        for (int r = 0; r < 16; r++) put(USR, 1'b0, 1'b0, r, 32'h1000_0000 + r);
        for (int r = 8; r < 15; r++) put(FST, 1'b0, 1'b0, r, 32'h2000_0000 + r);
        for (int r = 13; r < 15; r++) begin
            put(INT, 1'b0, 1'b0, r, 32'h3000_0000 + r);
            put(SVC, 1'b0, 1'b0, r, 32'h4000_0000 + r);
            put(ABT, 1'b0, 1'b0, r, 32'h5000_0000 + r);
            put(UND, 1'b0, 1'b0, r, 32'h6000_0000 + r);
        end
    endtask

    task automatic t_user_system;   // R1
        put(SYS, 1'b0, 1'b0, 10, 32'hA5A5_0010);
        put(SYS, 1'b0, 1'b0, 14, 32'hA5A5_0014);
        for (int r = 0; r < 16; r++) begin
            get("R1", USR, 1'b0, 1'b0, r);
            get("R1", ODD, 1'b0, 1'b0, r);
        end
        check("R1", rd_a_data, m_usr[15]);
    endtask

    task automatic t_fast;   // R2
        put(FST, 1'b0, 1'b0, 9, 32'hF00D_0009);
        get("R2", FST, 1'b0, 1'b0, 9);
        get("R2", USR, 1'b0, 1'b0, 9);
        put(USR, 1'b0, 1'b0, 12, 32'hBEEF_0012);
        get("R2", FST, 1'b0, 1'b0, 12);
        for (int r = 0; r < 16; r++) get("R2", FST, 1'b0, 1'b0, r);
    endtask

    task automatic t_short;   // R3
        for (int r = 8; r < 16; r++) begin
            get("R3", INT, 1'b0, 1'b0, r);
            get("R3", SVC, 1'b0, 1'b0, r);
            get("R3", ABT, 1'b0, 1'b0, r);
            get("R3", UND, 1'b0, 1'b0, r);
        end
        put(INT, 1'b0, 1'b0, 11, 32'hC0DE_0011);
        get("R3", USR, 1'b0, 1'b0, 11);
    endtask

    task automatic t_override;   // R4
        put(SVC, 1'b1, 1'b0, 13, 32'h0BAD_5013);
        get("R4", USR, 1'b0, 1'b0, 13);
        get("R4", SVC, 1'b0, 1'b0, 13);
        check("R4 restore low", 32'(restore_status), 32'd0);
        put(FST, 1'b1, 1'b0, 8, 32'h0BAD_F008);
        for (int r = 0; r < 16; r++) get("R4", FST, 1'b1, 1'b0, r);
        get("R4", FST, 1'b0, 1'b0, 8);
        get("R4", ABT, 1'b1, 1'b0, 14);
    endtask

    task automatic t_user_override;   // R5
        put(USR, 1'b1, 1'b0, 13, 32'h5555_0013);
        for (int r = 0; r < 16; r++) get("R5", USR, 1'b1, 1'b0, r);
        check("R5", rd_a_data, m_usr[15]);
        check("R5 restore low", 32'(restore_status), 32'd0);
    endtask

    task automatic t_restore;   // R6
        set_view(SVC, 1'b1, 1'b1); #1;
        check("R6 restore high", 32'(restore_status), 32'd1);
        put(SVC, 1'b1, 1'b1, 14, 32'h7777_0014);
        get("R6", SVC, 1'b0, 1'b0, 14);
        get("R6", USR, 1'b0, 1'b0, 14);
        set_view(USR, 1'b1, 1'b1); #1;
        check("R6 restore in user", 32'(restore_status), 32'd1);
        set_view(FST, 1'b0, 1'b1); #1;
        check("R6 no override", 32'(restore_status), 32'd0);
    endtask

    task automatic t_shared;   // R7
        put(UND, 1'b0, 1'b0, 15, 32'h1515_1515);
        put(FST, 1'b1, 1'b0, 3, 32'h0303_0303);
        get("R7", USR, 1'b0, 1'b0, 15);
        get("R7", FST, 1'b0, 1'b0, 15);
        get("R7", INT, 1'b1, 1'b0, 3);
        get("R7", SYS, 1'b0, 1'b0, 2);
    endtask

    task automatic t_same_cycle;   // R8
        @(negedge clk);
        set_view(ABT, 1'b0, 1'b0);
        rd_a_idx = 4'd13; rd_b_idx = 4'd13;
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hDEAD_0013;
        #1;
        check("R8 old value", rd_a_data, m_sh[2][0]);
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_wr(ABT, 1'b0, 1'b0, 13, 32'hDEAD_0013);
        check("R8 new value", rd_a_data, 32'hDEAD_0013);
        check("R10 port B", rd_b_data, 32'hDEAD_0013);
    endtask

    task automatic t_reset_again;   // R9
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        for (int r = 0; r < 16; r++) begin
            m_usr[r] = '0;
            if (r < 7) m_fst[r] = '0;
            if (r < 4) begin m_sh[r][0] = '0; m_sh[r][1] = '0; end
        end
        for (int r = 0; r < 16; r++) get("R9 after run", SVC, 1'b0, 1'b0, r);
        get("R9", FST, 1'b0, 1'b0, 10);
    endtask

    initial begin
        for (int r = 0; r < 16; r++) begin
            m_usr[r] = '0;
            if (r < 7) m_fst[r] = '0;
            if (r < 4) begin m_sh[r][0] = '0; m_sh[r][1] = '0; end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill();
        t_user_system();
        t_fast();
        t_short();
        t_override();
        t_user_override();
        t_restore();
        t_shared();
        t_same_cycle();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule